// File: doc/BRIEF.md
# Descriptor-Driven CRC Data Fetcher

This block feeds a CRC engine from memory. Software sets a descriptor pointer and an enable bit. It then writes a start command. The block reads a small descriptor from memory and finds the region to checksum. It works out how many bytes that region holds, then fetches the region word by word. The bytes go out to the CRC engine one per cycle.

The descriptor also carries a reference checksum and an interrupt-enable flag. The block captures both and holds them on outputs for the comparison and interrupt logic downstream. A one-cycle completion pulse marks the end of each job. The memory side is a simple read port with one request outstanding at a time. The block holds `mem_req` for one cycle, and the memory answers with `mem_rvalid` one or more cycles later.

Top module: `crc_desc_fetcher`

## Requirements
- R1: A write to register offset 0x00 keeps only data bits 31:9 as the descriptor pointer, with bits 8:0 reading as zero. The descriptor is fetched as three reads, in this order: pointer+0x00, pointer+0x04, then pointer+0x10.
- R2: The descriptor is decoded as follows. Word at +0x00 is the region start address. Word at +0x04 holds the unit count in bits 15:0, the width code in bits 25:24 and the interrupt-enable flag in bit 27. Word at +0x10 is the reference checksum. `ref_crc` and `ref_irq_en` hold the decoded values from the end of the fetch until the next job.
- R3: The byte length is the unit count times the unit size. Width code 1 gives 2 bytes per unit, code 2 gives 4 bytes per unit, and codes 0 and 3 give 1 byte per unit.
- R4: Region bytes leave on `crc_byte` with `crc_byte_valid`, one per cycle, in rising address order. Byte k of a fetched word is data bits 8k+7:8k. A start address that is not word aligned begins at its own byte lane. Data reads use the word-aligned address, and each word is read once.
- R5: A write to offset 0x08 with data bit 0 set starts a job only while the enable bit is 1. The enable bit is bit 0 of the register at offset 0x0C. With the enable bit at 0, the start command has no effect.
- R6: A start command that arrives while `busy` is high is ignored. No further memory reads or bytes result from it.
- R7: `busy` rises in the cycle after an accepted start command. It stays high through the `done` cycle and is low in the cycle after. While `busy` is low there is no memory request and no byte output.
- R8: `done` is a single-cycle pulse in the cycle right after the last region byte.
- R9: A unit count of zero produces no data reads and no bytes. `done` follows in the cycle right after the third descriptor word returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | REG_AW | Register byte offset |
| cfg_wr_data | input | 32 | Register write data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rdata | input | 32 | Returned read data |
| mem_rvalid | input | 1 | Read data valid |
| crc_byte_valid | output | 1 | Byte strobe to the CRC engine |
| crc_byte | output | 8 | Byte to the CRC engine |
| ref_crc | output | 32 | Reference checksum from the descriptor |
| ref_irq_en | output | 1 | Completion interrupt enable from the descriptor |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job-complete pulse |

## Verification
A wrong internal state here shows up at the ports quickly.
- A stale pointer, offset or lane shows as a wrong `mem_addr` on the very request it corrupts.
- A wrong lane or a missing word refill shows as a wrong value on the next `crc_byte`.
- A miscomputed length shows as an early or late `done`, or as bytes left over or missing when `done` arrives.
- A stuck sequencer shows as `busy` that never falls, or as requests while `busy` is low.

The reference model compares every request address, every byte and `busy` in every cycle. It checks the cycle of `done` against the last byte or the last descriptor word.

// File: rtl/crc_fetch_pkg.sv
package crc_fetch_pkg;

    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int LANE_W      = $clog2(WORD_BYTES);
    localparam int CNT_W       = 16;
    localparam int LEN_W       = CNT_W + 2;
    localparam int DESC_WORDS  = 3;
    localparam int WCODE_LSB   = 24;
    localparam int IRQ_BIT     = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_DATA_REQ,
        ST_DATA_WAIT,
        ST_EMIT,
        ST_DONE
    } fetch_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] src_addr;
        logic [CNT_W-1:0]  units;
        logic [1:0]        wcode;
        logic              irq_en;
        logic [WORD_W-1:0] ref_crc;
    } desc_t;

    // total byte length from unit count and width code
    function automatic logic [LEN_W-1:0] desc_bytes(input logic [CNT_W-1:0] units,
                                                    input logic [1:0] wcode);
        case (wcode)
            2'd1:    return {1'b0, units, 1'b0};
            2'd2:    return {units, 2'b00};
            default: return {2'b00, units};
        endcase
    endfunction

    // byte offset of the n-th descriptor word that is read
    function automatic logic [WORD_W-1:0] desc_word_offset(input logic [1:0] idx);
        case (idx)
            2'd0:    return 32'h0000_0000;
            2'd1:    return 32'h0000_0004;
            default: return 32'h0000_0010;
        endcase
    endfunction

endpackage

// File: rtl/crc_fetch_regs.sv
module crc_fetch_regs
    import crc_fetch_pkg::*;
#(
    parameter int REG_AW   = 8,
    parameter int BASE_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] desc_base,
    output logic              glb_en,
    output logic              start
);
    localparam logic [REG_AW-1:0] OFS_BASE = REG_AW'(8'h00);
    localparam logic [REG_AW-1:0] OFS_KICK = REG_AW'(8'h08);
    localparam logic [REG_AW-1:0] OFS_MODE = REG_AW'(8'h0C);
    localparam int PTR_W = WORD_W - BASE_LSB;

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            glb_en <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == OFS_BASE) ptr_q  <= wr_data[WORD_W-1:BASE_LSB];
            if (wr_addr == OFS_MODE) glb_en <= wr_data[0];
        end
    end

    assign desc_base = {ptr_q, {BASE_LSB{1'b0}}};
    assign start     = wr_en && (wr_addr == OFS_KICK) && wr_data[0] && glb_en;

endmodule

// File: rtl/crc_fetch_ctrl.sv
module crc_fetch_ctrl
    import crc_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] desc_base,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              word_load,
    output logic [LANE_W-1:0] word_lane,
    output logic              byte_emit,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] ref_crc,
    output logic              irq_en
);
    fetch_state_e      state;
    logic [1:0]        idx;
    desc_t             desc_q;
    logic [WORD_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  total_len;
    logic              last_desc;

    assign total_len = desc_bytes(desc_q.units, desc_q.wcode);
    assign last_desc = (idx == 2'(DESC_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            desc_q   <= '0;
            cur_addr <= '0;
            remain   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx   <= '0;
                        state <= ST_DESC_REQ;
                    end
                end
                ST_DESC_REQ: state <= ST_DESC_WAIT;
                ST_DESC_WAIT: begin
                    if (mem_rvalid) begin
                        case (idx)
                            2'd0: desc_q.src_addr <= mem_rdata;
                            2'd1: begin
                                desc_q.units  <= mem_rdata[CNT_W-1:0];
                                desc_q.wcode  <= mem_rdata[WCODE_LSB +: 2];
                                desc_q.irq_en <= mem_rdata[IRQ_BIT];
                            end
                            default: desc_q.ref_crc <= mem_rdata;
                        endcase
                        if (last_desc) begin
                            cur_addr <= desc_q.src_addr;
                            remain   <= total_len;
                            if (total_len == '0) state <= ST_DONE;
                            else                 state <= ST_DATA_REQ;
                        end else begin
                            idx   <= idx + 2'd1;
                            state <= ST_DESC_REQ;
                        end
                    end
                end
                ST_DATA_REQ: state <= ST_DATA_WAIT;
                ST_DATA_WAIT: begin
                    if (mem_rvalid) state <= ST_EMIT;
                end
                ST_EMIT: begin
                    remain   <= remain - LEN_W'(1);
                    cur_addr <= cur_addr + 32'd1;
                    if (remain == LEN_W'(1))
                        state <= ST_DONE;
                    else if (cur_addr[LANE_W-1:0] == {LANE_W{1'b1}})
                        state <= ST_DATA_REQ;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = (state == ST_DESC_REQ) || (state == ST_DATA_REQ);
        if (state == ST_DATA_REQ)
            mem_addr = {cur_addr[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
        else
            mem_addr = desc_base + desc_word_offset(idx);
    end

    assign word_load = (state == ST_DATA_WAIT) && mem_rvalid;
    assign word_lane = cur_addr[LANE_W-1:0];
    assign byte_emit = (state == ST_EMIT);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign ref_crc   = desc_q.ref_crc;
    assign irq_en    = desc_q.irq_en;

endmodule

// File: rtl/crc_fetch_ser.sv
module crc_fetch_ser
    import crc_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane_in,
    input  logic              emit,
    output logic [7:0]        byte_out
);
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic [7:0]        lanes [WORD_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            lane_q <= '0;
        end else if (load) begin
            word_q <= word_in;
            lane_q <= lane_in;
        end else if (emit) begin
            lane_q <= lane_q + LANE_W'(1);
        end
    end

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = word_q[g*8 +: 8];
    end

    assign byte_out = lanes[lane_q];

endmodule

// File: rtl/crc_desc_fetcher.sv
module crc_desc_fetcher
    import crc_fetch_pkg::*;
#(
    parameter int REG_AW   = 8,
    parameter int BASE_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic              crc_byte_valid,
    output logic [7:0]        crc_byte,
    output logic [31:0]       ref_crc,
    output logic              ref_irq_en,
    output logic              busy,
    output logic              done
);
    logic [WORD_W-1:0] desc_base;
    logic              glb_en;
    logic              start;
    logic              word_load;
    logic [LANE_W-1:0] word_lane;

    crc_fetch_regs #(.REG_AW(REG_AW), .BASE_LSB(BASE_LSB)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .desc_base (desc_base),
        .glb_en    (glb_en),
        .start     (start)
    );

    crc_fetch_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .desc_base  (desc_base),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .word_load  (word_load),
        .word_lane  (word_lane),
        .byte_emit  (crc_byte_valid),
        .busy       (busy),
        .done       (done),
        .ref_crc    (ref_crc),
        .irq_en     (ref_irq_en)
    );

    crc_fetch_ser i_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (word_load),
        .word_in  (mem_rdata),
        .lane_in  (word_lane),
        .emit     (crc_byte_valid),
        .byte_out (crc_byte)
    );

endmodule

// File: rtl/crc_desc_fetcher_chk.sv
module crc_desc_fetcher_chk #(
    parameter int REG_AW   = 8,
    parameter int BASE_LSB = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [REG_AW-1:0] cfg_wr_addr,
    input logic [31:0]       cfg_wr_data,
    input logic              glb_en,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              crc_byte_valid
);
    // R5: a job only begins after a start write while enabled
    p_start_gated_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_wr_en && (cfg_wr_addr == REG_AW'(8'h08)) && cfg_wr_data[0] && glb_en));

    // R1: first request of a job hits an aligned descriptor pointer
    p_desc_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_req && (mem_addr[BASE_LSB-1:0] == '0)));

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: busy drops right after done and only then
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R7: quiet memory and byte ports while not busy
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !crc_byte_valid));

    // R4: bytes are never emitted in a cycle that issues a read
    p_emit_no_req_r4: assert property (@(posedge clk) disable iff (rst)
        crc_byte_valid |-> !mem_req);
endmodule

bind crc_desc_fetcher crc_desc_fetcher_chk #(.REG_AW(REG_AW), .BASE_LSB(BASE_LSB)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_addr    (cfg_wr_addr),
    .cfg_wr_data    (cfg_wr_data),
    .glb_en         (glb_en),
    .busy           (busy),
    .done           (done),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .crc_byte_valid (crc_byte_valid)
);

// File: tb/test_crc_desc_fetcher.sv
`timescale 1ns/1ps
module test_crc_desc_fetcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        crc_byte_valid;
    logic [7:0]  crc_byte;
    logic [31:0] ref_crc;
    logic        ref_irq_en;
    logic        busy;
    logic        done;

    always #4 clk = ~clk;

    crc_desc_fetcher i_crc_desc_fetcher (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .crc_byte_valid(crc_byte_valid), .crc_byte(crc_byte),
        .ref_crc(ref_crc), .ref_irq_en(ref_irq_en), .busy(busy), .done(done)
    );

    int errors = 0;
    int checks = 0;
    logic [31:0] mem [0:1023];

    // reference model state
    logic [31:0] m_base = '0;
    logic        m_en = 1'b0;
    logic        m_busy = 1'b0;
    logic [31:0] exp_ref = '0;
    logic        exp_irq = 1'b0;
    int          exp_len = 0;
    logic [31:0] exp_addrs [$];
    logic [7:0]  exp_bytes [$];
    int cyc = 0;
    int last_rv_cyc = -10;
    int last_byte_cyc = -10;
    logic done_last = 1'b0;
    logic monitor_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic build_expect();
        logic [31:0] w1, src, a;
        int unit;
        src = mem[m_base[11:2]];
        w1  = mem[m_base[11:2] + 10'd1];
        exp_ref = mem[m_base[11:2] + 10'd4];
        exp_irq = w1[27];
        unit = (w1[25:24] == 2'd1) ? 2 : (w1[25:24] == 2'd2) ? 4 : 1;
        exp_len = int'(w1[15:0]) * unit;
        exp_addrs.push_back(m_base);
        exp_addrs.push_back(m_base + 32'h4);
        exp_addrs.push_back(m_base + 32'h10);
        for (int k = 0; k < exp_len; k++) begin
            a = src + 32'(k);
            if (k == 0 || a[1:0] == 2'b00) exp_addrs.push_back({a[31:2], 2'b00});
            exp_bytes.push_back(mem_byte(a));
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bit accept;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        accept = (a == 8'h08) && d[0] && m_en && !m_busy;
        if (accept) build_expect();
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        if (a == 8'h00) m_base = d & 32'hFFFF_FE00;
        if (a == 8'h0C) m_en = d[0];
        if (accept) m_busy = 1'b1;
    endtask

    task automatic set_desc(input logic [31:0] base, input logic [31:0] src,
                            input logic [15:0] units, input logic [1:0] code,
                            input logic irq, input logic [31:0] refv);
        mem[base[11:2]]         = src;
        mem[base[11:2] + 10'd1] = {4'hA, irq, 1'b1, code, 8'h5A, units};
        mem[base[11:2] + 10'd2] = 32'hDEAD_0002;
        mem[base[11:2] + 10'd3] = 32'hDEAD_0003;
        mem[base[11:2] + 10'd4] = refv;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (m_busy && n < 3000) begin @(negedge clk); n++; end
        chk(!m_busy, "R7", "job did not finish", {31'd0, m_busy}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    // memory responder: one request in flight, latency 1..3
    initial begin
        int pend = 0;
        int lat_seq = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[paddr[11:2]];
                end
            end else if (mem_req) begin
                paddr = mem_addr;
                pend  = 1 + (lat_seq % 3);
                lat_seq++;
            end
        end
    end

    // cycle monitor and reference comparison
    initial begin
        forever begin
            @(negedge clk); #1;
            cyc++;
            if (monitor_on) begin
                if (done_last) m_busy = 1'b0;
                chk(busy == m_busy, "R7", "busy", {31'd0, busy}, {31'd0, m_busy});
                if (mem_rvalid) last_rv_cyc = cyc;
                if (mem_req) begin
                    if (exp_addrs.size() == 0)
                        chk(1'b0, "R6", "unexpected mem_req", mem_addr, 32'hFFFF_FFFF);
                    else begin
                        logic [31:0] ea;
                        ea = exp_addrs.pop_front();
                        chk(mem_addr == ea, "R1", "mem_addr (descriptor/data, R4)", mem_addr, ea);
                    end
                end
                if (crc_byte_valid) begin
                    last_byte_cyc = cyc;
                    if (exp_bytes.size() == 0)
                        chk(1'b0, "R6", "unexpected byte", {24'd0, crc_byte}, 32'hFFFF_FFFF);
                    else begin
                        logic [7:0] eb;
                        eb = exp_bytes.pop_front();
                        chk(crc_byte == eb, "R4", "crc_byte", {24'd0, crc_byte}, {24'd0, eb});
                    end
                end
                if (done) begin
                    chk(exp_bytes.size() == 0, "R3", "bytes missing at done",
                        32'(exp_bytes.size()), 32'd0);
                    chk(exp_addrs.size() == 0, "R3", "reads missing at done",
                        32'(exp_addrs.size()), 32'd0);
                    chk(ref_crc == exp_ref, "R2", "ref_crc", ref_crc, exp_ref);
                    chk(ref_irq_en == exp_irq, "R2", "ref_irq_en",
                        {31'd0, ref_irq_en}, {31'd0, exp_irq});
                    if (exp_len == 0)
                        chk(cyc == last_rv_cyc + 1, "R9", "done cycle after descriptor",
                            32'(cyc), 32'(last_rv_cyc + 1));
                    else
                        chk(cyc == last_byte_cyc + 1, "R8", "done cycle after last byte",
                            32'(cyc), 32'(last_byte_cyc + 1));
                end
                done_last = done;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            logic [7:0] b;
            b = 8'(i);
            mem[i] = {b ^ 8'h3C, b + 8'h11, ~b, b};
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // reset state
        chk(busy == 1'b0, "R7", "reset busy", {31'd0, busy}, 32'd0);
        chk(done == 1'b0, "R8", "reset done", {31'd0, done}, 32'd0);
        chk(mem_req == 1'b0, "R7", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk(crc_byte_valid == 1'b0, "R7", "reset byte_valid", {31'd0, crc_byte_valid}, 32'd0);
        monitor_on = 1'b1;

        // R5: start while disabled is ignored
        set_desc(32'h200, 32'h100, 16'd5, 2'd0, 1'b0, 32'h1234_5678);
        wr(8'h00, 32'h0000_0200);
        wr(8'h08, 32'h1);
        repeat (10) @(negedge clk);
        #1 chk(busy == 1'b0, "R5", "busy after disabled start", {31'd0, busy}, 32'd0);

        // R3 byte units, aligned region
        wr(8'h0C, 32'h1);
        wr(8'h08, 32'h1);
        wait_idle();

        // R1 reserved low pointer bits, R3 halfword units, R4 unaligned start, R2 irq flag
        set_desc(32'h400, 32'h302, 16'd3, 2'd1, 1'b1, 32'hCAFE_F00D);
        wr(8'h00, 32'h0000_05FF);
        wr(8'h08, 32'h1);
        wait_idle();

        // R3 word units, R6 start during busy ignored
        set_desc(32'h600, 32'h800, 16'd4, 2'd2, 1'b0, 32'h0BAD_BEEF);
        wr(8'h00, 32'h0000_0600);
        wr(8'h08, 32'h1);
        repeat (12) @(negedge clk);
        wr(8'h08, 32'h1);
        wait_idle();

        // R3 code 3 counts bytes, unaligned at lane 1
        set_desc(32'hA00, 32'hC01, 16'd6, 2'd3, 1'b1, 32'h5555_AAAA);
        wr(8'h00, 32'h0000_0A00);
        wr(8'h08, 32'h1);
        wait_idle();

        // R9 zero count
        set_desc(32'h200, 32'h100, 16'd0, 2'd2, 1'b1, 32'h7777_0000);
        wr(8'h00, 32'h0000_0200);
        wr(8'h08, 32'h1);
        wait_idle();

        // R5 disabling again blocks starts
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h1);
        repeat (8) @(negedge clk);
        #1 chk(busy == 1'b0, "R5", "busy after start with enable cleared", {31'd0, busy}, 32'd0);

        repeat (5) @(negedge clk);
        chk(exp_bytes.size() == 0 && exp_addrs.size() == 0, "R6", "leftover expectations",
            32'(exp_bytes.size() + exp_addrs.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule